// File: doc/BRIEF.md
# Converter Sample Transport Framer

This block sits between a group of data converters and the lane encoders of a serial link. Once per frame it takes one set of parallel samples, `S` from each of `M` converters. It widens every sample into a nibble-aligned link word, with optional control bits below the sample and zero tail bits filling the rest. The words are joined into one frame stream, which is cut into octets and dealt out over `L` lanes. Each lane then sends its share of the frame as one octet per clock, over `F` cycles.

The clock is the octet clock, and a frame lasts `F = M*S*NP/(8*L)` cycles. All shape parameters are fixed at elaboration, and an unsupported combination stops elaboration with an error. The block keeps an octet counter within the frame and a frame counter within the multiframe. From these it drives per-lane frame-start and multiframe-start flags, which a downstream encoder can use to insert alignment characters.

The upstream side watches `smp_rdy`. The samples present in the cycle where it is high are taken if `smp_valid` is high. If `smp_valid` is low, the next frame is sent as all-zero octets with `idle` raised.

Top module: `tl_framer`

## Requirements
- R1: Each link word is NP bits. The N-bit sample fills bits NP-1 down to NP-N. The CS control bits follow directly below the sample LSB. The remaining T = NP-N-CS low bits are zero.
- R2: F is computed from M, S, NP and L. Elaboration fails if M*S*NP is not a multiple of 8*L, if NP is not a multiple of 4 or is smaller than N+CS, or if K is outside 1..32.
- R3: Word w = m*S+s (converter m, sample s) is read from `smp_data[w*N +: N]` and `smp_ctrl[w*CS +: CS]`. The frame stream puts word 0 in its most significant bits, then word 1, and so on. Lane l carries stream octets l*F .. l*F+F-1, most significant octet first, on `lane_octet[l*8 +: 8]`.
- R4: All lanes advance together, so in any cycle every lane sends the same octet index of the same frame.
- R5: `smp_rdy` is high in the last octet cycle of every frame and in the first cycle after reset, and low otherwise. Samples are taken only in those cycles and are sent from the next cycle for exactly F cycles. Input changes in other cycles have no effect.
- R6: If `smp_valid` is low when samples are taken, every lane sends zero octets and `idle` is high for the whole next frame. `idle` is low during a frame that carries samples.
- R7: On every lane, `lane_fs` is high in the first octet cycle of each frame and low in all other cycles.
- R8: Frames are counted 0..K-1 and then wrap to 0. The first frame after reset is frame 0. `lane_mfs` is high on every lane only in octet 0 of frame 0. Idle frames are counted too.
- R9: During reset, all octets are zero, `lane_fs` and `lane_mfs` are low, `idle` is high and `smp_rdy` is high.
- R10: With CS = 0 and N = NP, each link word equals its sample exactly, and `smp_ctrl` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Samples present are valid in a take cycle |
| smp_data | input | M*S*N | Samples, word w at bits w*N upward |
| smp_ctrl | input | M*S*max(CS,1) | Control bits, word w at bits w*CS upward |
| smp_rdy | output | 1 | Take cycle: last octet of the current frame |
| lane_octet | output | L*8 | One octet per lane, lane l at bits l*8 upward |
| lane_fs | output | L | Per-lane frame-start flag |
| lane_mfs | output | L | Per-lane multiframe-start flag |
| idle | output | 1 | Current frame carries no samples |

## Verification
The bench builds three versions of the block. The first has four 14-bit converters with one control bit on four lanes (F=2, K=4), where each lane carries one converter. The second has two samples per converter of 12-bit data with two control bits on eight lanes (F=2, K=3), so each converter's samples are spread over two lanes in lock-step. The third has two 16-bit converters on a single lane with no control bits (F=4, K=2). Between them they cover words with and without tail and control bits, lanes that split a converter, several octets per frame, and multiframe wrap at different K. Each frame is rebuilt from the lane octets and split back into sample, control and tail fields. Inputs are changed in the middle of frames and idle frames are mixed in.

// File: rtl/tl_framer_pkg.sv
package tl_framer_pkg;

    // octets each lane sends per frame
    function automatic int octets_per_lane(input int m, input int s, input int np, input int l);
        return (m * s * np) / (8 * l);
    endfunction

    // index width that is never zero
    function automatic int idx_width(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/tl_frame_cnt.sv
module tl_frame_cnt #(
    parameter int F  = 2,
    parameter int K  = 4,
    parameter int OW = 1,
    parameter int KW = 2
) (
    input  logic          clk,
    input  logic          rst,
    output logic [OW-1:0] oct_idx,
    output logic [KW-1:0] frm_idx,
    output logic          last_oct,
    output logic          run
);

    typedef struct packed {
        logic [OW-1:0] oct;
        logic [KW-1:0] frm;
        logic          run;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.run = 1'b1;
        if (cnt_q.oct == OW'(F - 1)) begin
            cnt_d.oct = '0;
            cnt_d.frm = (cnt_q.frm == KW'(K - 1)) ? '0 : cnt_q.frm + 1'b1;
        end else begin
            cnt_d.oct = cnt_q.oct + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q.oct <= OW'(F - 1);
            cnt_q.frm <= KW'(K - 1);
            cnt_q.run <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign oct_idx  = cnt_q.oct;
    assign frm_idx  = cnt_q.frm;
    assign last_oct = (cnt_q.oct == OW'(F - 1));
    assign run      = cnt_q.run;

    AST_OCT_WRAP: assert property (@(posedge clk) disable iff (rst)
        last_oct |=> (oct_idx == '0)); // R7
    AST_FRM_WRAP: assert property (@(posedge clk) disable iff (rst)
        (last_oct && frm_idx == KW'(K - 1)) |=> (frm_idx == '0)); // R8
    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!last_oct && run) |=> $stable(frm_idx)); // R8

endmodule

// File: rtl/tl_word_pack.sv
module tl_word_pack #(
    parameter int WN  = 4,
    parameter int N   = 14,
    parameter int NP  = 16,
    parameter int CS  = 1,
    parameter int CSW = 1
) (
    input  logic [WN*N-1:0]   smp_i,
    input  logic [WN*CSW-1:0] ctl_i,
    output logic [WN*NP-1:0]  frame_o
);

    localparam int FB = WN * NP;
    localparam int T  = NP - N - CS;

    logic [NP-1:0] word;

    always_comb begin
        frame_o = '0;
        word    = '0;
        for (int w = 0; w < WN; w++) begin
            word = NP'(smp_i[w*N +: N]) << (NP - N);
            if (CS > 0) begin
                word = word | (NP'(ctl_i[w*CSW +: CSW]) << T);
            end
            frame_o[FB-1-w*NP -: NP] = word;
        end
    end

endmodule

// File: rtl/tl_lane_map.sv
module tl_lane_map #(
    parameter int L  = 4,
    parameter int F  = 2,
    parameter int FB = 64,
    parameter int OW = 1
) (
    input  logic [FB-1:0]  frame_i,
    input  logic [OW-1:0]  oct_idx,
    output logic [L*8-1:0] octet_o
);

    for (genvar l = 0; l < L; l++) begin : g_lane
        always_comb begin
            octet_o[l*8 +: 8] = '0;
            for (int o = 0; o < F; o++) begin
                if (oct_idx == OW'(o)) begin
                    octet_o[l*8 +: 8] = frame_i[FB-1-8*(l*F+o) -: 8];
                end
            end
        end
    end

endmodule

// File: rtl/tl_framer.sv
module tl_framer #(
    parameter int M  = 4,
    parameter int N  = 14,
    parameter int NP = 16,
    parameter int CS = 1,
    parameter int S  = 1,
    parameter int L  = 4,
    parameter int K  = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                smp_valid,
    input  logic [M*S*N-1:0]                    smp_data,
    input  logic [M*S*((CS > 0) ? CS : 1)-1:0]  smp_ctrl,
    output logic                                smp_rdy,
    output logic [L*8-1:0]                      lane_octet,
    output logic [L-1:0]                        lane_fs,
    output logic [L-1:0]                        lane_mfs,
    output logic                                idle
);

    import tl_framer_pkg::*;

    localparam int WN  = M * S;
    localparam int FB  = WN * NP;
    localparam int F   = octets_per_lane(M, S, NP, L);
    localparam int CSW = (CS > 0) ? CS : 1;
    localparam int OW  = idx_width(F);
    localparam int KW  = idx_width(K);

    // R2: reject shapes the framer cannot carry
    if ((FB % (8 * L)) != 0) begin : g_bad_lanes
        $error("frame bits do not split evenly into lane octets");
    end
    if ((NP % 4) != 0 || NP < N + CS) begin : g_bad_word
        $error("word size must be a nibble multiple holding sample and control bits");
    end
    if (K < 1 || K > 32) begin : g_bad_k
        $error("frames per multiframe must be 1 to 32");
    end

    typedef struct packed {
        logic [FB-1:0] frame;
        logic          vld;
    } hold_t;

    hold_t         hold_d, hold_q;
    logic [FB-1:0] packed_frame;
    logic [OW-1:0] oct_idx;
    logic [KW-1:0] frm_idx;
    logic          last_oct;
    logic          run;

    tl_frame_cnt #(.F(F), .K(K), .OW(OW), .KW(KW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .oct_idx  (oct_idx),
        .frm_idx  (frm_idx),
        .last_oct (last_oct),
        .run      (run)
    );

    tl_word_pack #(.WN(WN), .N(N), .NP(NP), .CS(CS), .CSW(CSW)) u_pack (
        .smp_i   (smp_data),
        .ctl_i   (smp_ctrl),
        .frame_o (packed_frame)
    );

    always_comb begin
        hold_d = hold_q;
        if (last_oct) begin
            hold_d.vld   = smp_valid;
            hold_d.frame = smp_valid ? packed_frame : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    tl_lane_map #(.L(L), .F(F), .FB(FB), .OW(OW)) u_map (
        .frame_i (hold_q.frame),
        .oct_idx (oct_idx),
        .octet_o (lane_octet)
    );

    assign smp_rdy  = last_oct;
    assign idle     = ~hold_q.vld;
    assign lane_fs  = {L{run && (oct_idx == '0)}};
    assign lane_mfs = {L{run && (oct_idx == '0) && (frm_idx == '0)}};

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        idle |-> (lane_octet == '0)); // R6
    AST_RDY_THEN_FS: assert property (@(posedge clk) disable iff (rst)
        smp_rdy |=> lane_fs[0]); // R7
    AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (rst)
        !smp_rdy |=> $stable(hold_q)); // R5
    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
        (lane_fs == '0) || (&lane_fs)); // R4
    AST_MFS_IN_FS: assert property (@(posedge clk) disable iff (rst)
        (lane_mfs & ~lane_fs) == '0); // R8

endmodule

// File: tb/tl_framer_tb.sv
module tl_framer_harness #(
    parameter int CFG = 0,
    parameter int M   = 4,
    parameter int N   = 14,
    parameter int NP  = 16,
    parameter int CS  = 1,
    parameter int S   = 1,
    parameter int L   = 4,
    parameter int K   = 4
) (
    input  logic clk,
    input  logic rst,
    output int   n_err,
    output int   n_chk,
    output logic done
);

    localparam int WN  = M * S;
    localparam int FB  = WN * NP;
    localparam int F   = FB / (8 * L);
    localparam int CSW = (CS > 0) ? CS : 1;
    localparam int T   = NP - N - CS;

    // {valid, pattern[1:0], seed[7:0]}
    localparam logic [10:0] STIM [12] = '{
        {1'b1, 2'd0, 8'd3},   {1'b1, 2'd1, 8'd0},   {1'b0, 2'd0, 8'd9},
        {1'b1, 2'd2, 8'd0},   {1'b1, 2'd3, 8'd0},   {1'b1, 2'd0, 8'd77},
        {1'b0, 2'd1, 8'd0},   {1'b0, 2'd3, 8'd1},   {1'b1, 2'd0, 8'd201},
        {1'b1, 2'd3, 8'd5},   {1'b1, 2'd0, 8'd140}, {1'b1, 2'd1, 8'd2}
    };

    logic                smp_valid;
    logic [WN*N-1:0]     smp_data;
    logic [WN*CSW-1:0]   smp_ctrl;
    logic                smp_rdy;
    logic [L*8-1:0]      lane_octet;
    logic [L-1:0]        lane_fs;
    logic [L-1:0]        lane_mfs;
    logic                idle;
    int                  tf;

    tl_framer #(.M(M), .N(N), .NP(NP), .CS(CS), .S(S), .L(L), .K(K)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .smp_ctrl   (smp_ctrl),
        .smp_rdy    (smp_rdy),
        .lane_octet (lane_octet),
        .lane_fs    (lane_fs),
        .lane_mfs   (lane_mfs),
        .idle       (idle)
    );

    function automatic int gen(input int mode, input int seed, input int w, input int salt);
        case (mode)
            0:       return (seed * 40503 + w * 2654435 + salt * 977) ^ (seed << 7) ^ (w << 3);
            1:       return -1;
            2:       return 0;
            default: return ((w + salt) % 2 == 0) ? 32'h5555 : 32'hAAAA;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL cfg%0d %s: act=%0h exp=%0h", CFG, req, act, exp);
        end
    endtask

    task automatic drive(input bit vld, input int mode, input int seed, input int salt);
        smp_valid = vld;
        for (int w = 0; w < WN; w++) begin
            smp_data[w*N +: N]     = N'(gen(mode, seed, w, salt));
            smp_ctrl[w*CSW +: CSW] = CSW'(gen(mode, seed, w, salt + 1));
        end
    endtask

    task automatic run_frame(input bit vld, input int mode, input int seed);
        logic [FB-1:0] obs;
        int            obsw;
        int            exp_d;
        int            exp_c;
        longint        exp_mfs;
        obs = '0;
        chk(smp_rdy == 1'b1, "R5 take cycle", smp_rdy, 1);
        drive(vld, mode, seed, 0);
        for (int o = 0; o < F; o++) begin
            @(negedge clk);
            chk(lane_fs == {L{(o == 0)}}, "R7 frame start", lane_fs, {L{(o == 0)}});
            exp_mfs = (o == 0 && (tf % K) == 0) ? {L{1'b1}} : 0;
            chk(longint'(lane_mfs) == exp_mfs, "R8 multiframe start", lane_mfs, exp_mfs);
            chk(idle == !vld, "R6 idle flag", idle, !vld);
            if (vld) begin
                for (int l = 0; l < L; l++) begin
                    obs[FB-1-8*(l*F+o) -: 8] = lane_octet[l*8 +: 8];
                end
            end else begin
                chk(lane_octet == '0, "R6 zero octets", lane_octet, 0);
            end
            if (o < F - 1) begin
                chk(smp_rdy == 1'b0, "R5 no take mid-frame", smp_rdy, 0);
                drive(!vld, 0, seed + 99, 2 + o);
            end
        end
        tf++;
        if (vld) begin
            for (int w = 0; w < WN; w++) begin
                obsw  = int'(obs[FB-1-w*NP -: NP]);
                exp_d = gen(mode, seed, w, 0) & ((1 << N) - 1);
                exp_c = gen(mode, seed, w, 1) & ((1 << CS) - 1);
                if (CS == 0) begin
                    chk(obsw == exp_d, "R10 word equals sample", obsw, exp_d);
                end
                chk((obsw >> (NP - N)) == exp_d, "R3 sample from lanes", obsw >> (NP - N), exp_d);
                chk(((obsw >> T) & ((1 << CS) - 1)) == exp_c, "R1 control bits",
                    (obsw >> T) & ((1 << CS) - 1), exp_c);
                chk((obsw & ((1 << T) - 1)) == 0, "R1 tail zero", obsw & ((1 << T) - 1), 0);
            end
        end
    endtask

    initial begin
        n_err     = 0;
        n_chk     = 0;
        done      = 1'b0;
        tf        = 0;
        smp_valid = 1'b0;
        smp_data  = '0;
        smp_ctrl  = '0;
        // directed: reset state (R9)
        repeat (2) @(negedge clk);
        chk(lane_octet == '0, "R9 reset octets", lane_octet, 0);
        chk(lane_fs == '0, "R9 reset fs", lane_fs, 0);
        chk(lane_mfs == '0, "R9 reset mfs", lane_mfs, 0);
        chk(idle == 1'b1, "R9 reset idle", idle, 1);
        chk(smp_rdy == 1'b1, "R9 reset rdy", smp_rdy, 1);
        wait (!rst);
        @(negedge clk);
        // table walk: R1 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 12; i++) begin
            run_frame(STIM[i][10], int'(STIM[i][9:8]), int'(STIM[i][7:0]));
        end
        // directed corner: idle frame followed at once by full-scale samples
        run_frame(1'b0, 0, 11);
        run_frame(1'b1, 1, 0);
        run_frame(1'b1, 0, 250);
        done = 1'b1;
    end

endmodule

module tl_framer_tb;

    logic clk;
    logic rst;
    int   e_a, c_a, e_b, c_b, e_c, c_c;
    logic d_a, d_b, d_c;
    bit   timeout;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    end

    // one converter per lane, tail and control bits present
    tl_framer_harness #(.CFG(0), .M(4), .N(14), .NP(16), .CS(1), .S(1), .L(4), .K(4)) u_cfg_a (
        .clk(clk), .rst(rst), .n_err(e_a), .n_chk(c_a), .done(d_a));
    // two samples per converter spread over two lanes
    tl_framer_harness #(.CFG(1), .M(4), .N(12), .NP(16), .CS(2), .S(2), .L(8), .K(3)) u_cfg_b (
        .clk(clk), .rst(rst), .n_err(e_b), .n_chk(c_b), .done(d_b));
    // full-width samples, no control bits, single lane
    tl_framer_harness #(.CFG(2), .M(2), .N(16), .NP(16), .CS(0), .S(1), .L(1), .K(2)) u_dut (
        .clk(clk), .rst(rst), .n_err(e_c), .n_chk(c_c), .done(d_c));

    initial begin
        int errs;
        int chks;
        timeout = 1'b0;
        fork
            wait (d_a && d_b && d_c);
            begin
                repeat (20000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        errs = e_a + e_b + e_c;
        chks = c_a + c_b + c_c;
        if (timeout) begin
            errs++;
            chks++;
            $display("FAIL R5 watchdog: act=running exp=done");
        end
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

endmodule